// File: doc/BRIEF.md
# Serial Clock Divider and Edge Phase Generator

This block produces the serial clock of a SPI host from a fast source clock. An integer divider sets the rate. A three-bit mode field sets the level SCLK rests at and picks two edges on its own: the edge on which outgoing data changes and the edge on which incoming data is captured. For each of these edges the block gives the datapath a one-cycle strobe. The strobe is high in the source cycle in which SCLK first shows the new level.

Software raises a run request to start clocking and drops it to stop. When a transfer starts, the block takes a snapshot of the divider and the mode field, so changes made to them during a transfer take effect at the next start. When chip select 1 is the active select and its alternate divider is enabled, the alternate divider is used instead of the main one. The shift register, the FIFOs and the chip-select timing sit outside this block.

Top module: `spi_sclk_gen`

## Requirements
- R1: While no transfer is active (after reset, or once a transfer has ended), `sclk` equals `mode[0]`, and `shift_stb` and `sample_stb` are both 0.
- R2: A nonzero divider value N of 2 or more gives an SCLK period of exactly N source cycles. SCLK is high for floor(N/2) cycles and low for the remaining N - floor(N/2) cycles.
- R3: A divider value of 0 divides by 2^DIV_W (256 with the default width), with equal high and low halves.
- R4: A divider value of 1 passes the source clock through. While the transfer runs, `sclk` is high during the high phase of `clk` when `mode[0]`=0 and is inverted when `mode[0]`=1. Both strobes stay at 1 every cycle.
- R5: Run is seen at source edge E0. The first leading (idle-to-active) SCLK edge appears at edge E0+L. L is the length of the idle-level half: N - floor(N/2) cycles when `mode[0]`=0, floor(N/2) cycles when `mode[0]`=1.
- R6: `mode[1]` (output phase) = 0 asserts `shift_stb` on trailing (active-to-idle) edges. `mode[1]` = 1 asserts it on leading edges.
- R7: `mode[2]` (input phase) = 0 asserts `sample_stb` on leading edges. `mode[2]` = 1 asserts it on trailing edges. When `mode[2]` differs from `mode[1]`, the two strobes fall in the same cycles.
- R8: The divider is taken from `div_alt` when both `alt_en` and `cs1_sel` are 1, and from `div_main` otherwise. The same zero and one encodings apply to both.
- R9: Divider, alternate-divider and mode inputs are captured when a transfer starts. Changing them while the transfer runs does not alter its waveform.
- R10: Once `run` is low, no further leading edge occurs. A pending trailing edge still completes, then SCLK rests at its idle level. In divide-by-1 mode clocking stops at the first source edge that sees `run` low.
- R11: Mode bit positions: bit 0 is polarity (1 = SCLK idles high), bit 1 is output phase, bit 2 is input phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run request; high starts or continues clocking |
| cs1_sel | input | 1 | Chip select 1 is the active select |
| div_main | input | DIV_W | Main divider (0 means 2^DIV_W) |
| div_alt | input | DIV_W | Alternate divider used for chip select 1 |
| alt_en | input | 1 | Enables the alternate divider |
| mode | input | 3 | {input phase, output phase, polarity} |
| sclk | output | 1 | Serial clock |
| shift_stb | output | 1 | One-cycle strobe: change outgoing data now |
| sample_stb | output | 1 | One-cycle strobe: capture incoming data now |

## Verification
A wrong half-period count shows up at the first SCLK edge, which arrives one or more source cycles early or late. The bench compares every cycle of each transfer against an arithmetic model, so this is seen within one divider period of the start. A wrong phase mapping or a wrong edge classification makes a strobe appear on the wrong SCLK edge; this is caught at the first edge of the transfer. A stale or unlatched configuration, or a stop that still lets a leading edge through, shows as a waveform that departs from the model within one period of the change or of the drop of `run`.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  // Level of SCLK relative to its idle level
  typedef enum logic {
    LVL_IDLE   = 1'b0,
    LVL_ACTIVE = 1'b1
  } lvl_e;

  // Mode field layout: bit 0 polarity, bit 1 output phase, bit 2 input phase
  typedef struct packed {
    logic cpha_in;
    logic cpha_out;
    logic cpol;
  } mode_t;

endpackage

// File: rtl/spi_sclk_div_sel.sv
module spi_sclk_div_sel #(
  parameter int DIV_W = 8,
  localparam int CW = DIV_W + 1
) (
  input  logic [DIV_W-1:0] div_main,
  input  logic [DIV_W-1:0] div_alt,
  input  logic             alt_en,
  input  logic             cs1_sel,
  output logic [CW-1:0]    len_hi,
  output logic [CW-1:0]    len_lo,
  output logic             bypass
);

  logic [DIV_W-1:0] sel;
  logic [CW-1:0]    n_eff;

  assign sel    = (alt_en && cs1_sel) ? div_alt : div_main;
  // zero encodes the full range of the field
  assign n_eff  = (sel == '0) ? (CW'(1) << DIV_W) : {1'b0, sel};
  assign len_hi = n_eff >> 1;
  assign len_lo = n_eff - len_hi;
  assign bypass = (n_eff == CW'(1));

endmodule

// File: rtl/spi_sclk_half_timer.sv
module spi_sclk_half_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] len,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  assign done = en && (cnt_q == len - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !en || done) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/spi_sclk_edge_map.sv
module spi_sclk_edge_map (
  input  logic clk,
  input  logic rst,
  input  logic lead,
  input  logic trail,
  input  logic byp,
  input  logic cpha_out,
  input  logic cpha_in,
  output logic shift_stb,
  output logic sample_stb
);

  logic shift_q, sample_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      shift_q  <= cpha_out ? lead : trail;
      sample_q <= cpha_in  ? trail : lead;
    end
  end

  // in pass-through mode every source cycle carries both edges
  assign shift_stb  = shift_q  | byp;
  assign sample_stb = sample_q | byp;

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cs1_sel,
  input  logic [DIV_W-1:0] div_main,
  input  logic [DIV_W-1:0] div_alt,
  input  logic             alt_en,
  input  logic [2:0]       mode,
  output logic             sclk,
  output logic             shift_stb,
  output logic             sample_stb
);

  localparam int CW = DIV_W + 1;

  logic [CW-1:0] len_hi_c, len_lo_c;
  logic          byp_c;

  logic          active_q, byp_q, sclk_q;
  lvl_e          level_q;
  mode_t         mode_q;
  logic [CW-1:0] hi_q, lo_q;

  logic          half_done, lead_ev, trail_ev, cur_hi, timing;
  logic [CW-1:0] cur_len;

  spi_sclk_div_sel #(.DIV_W(DIV_W)) u_sel (
    .div_main (div_main),
    .div_alt  (div_alt),
    .alt_en   (alt_en),
    .cs1_sel  (cs1_sel),
    .len_hi   (len_hi_c),
    .len_lo   (len_lo_c),
    .bypass   (byp_c)
  );

  assign timing  = active_q & ~byp_q;
  assign cur_hi  = mode_q.cpol ^ (level_q == LVL_ACTIVE);
  assign cur_len = cur_hi ? hi_q : lo_q;

  spi_sclk_half_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .en   (timing),
    .len  (cur_len),
    .done (half_done)
  );

  assign lead_ev  = timing & half_done & (level_q == LVL_IDLE) & run;
  assign trail_ev = timing & half_done & (level_q == LVL_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      byp_q    <= 1'b0;
      level_q  <= LVL_IDLE;
      sclk_q   <= mode[0];
      mode_q   <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (!active_q) begin
      sclk_q  <= mode[0];
      level_q <= LVL_IDLE;
      if (run) begin
        active_q <= 1'b1;
        byp_q    <= byp_c;
        mode_q   <= mode_t'(mode);
        hi_q     <= len_hi_c;
        lo_q     <= len_lo_c;
      end
    end else if (byp_q) begin
      if (!run) begin
        active_q <= 1'b0;
        byp_q    <= 1'b0;
      end
    end else if (half_done) begin
      if (level_q == LVL_IDLE) begin
        if (run) begin
          level_q <= LVL_ACTIVE;
          sclk_q  <= ~sclk_q;
        end else begin
          active_q <= 1'b0;
        end
      end else begin
        level_q <= LVL_IDLE;
        sclk_q  <= ~sclk_q;
      end
    end
  end

  spi_sclk_edge_map u_map (
    .clk        (clk),
    .rst        (rst),
    .lead       (lead_ev),
    .trail      (trail_ev),
    .byp        (byp_q),
    .cpha_out   (mode_q.cpha_out),
    .cpha_in    (mode_q.cpha_in),
    .shift_stb  (shift_stb),
    .sample_stb (sample_stb)
  );

  // divide-by-1 gates the source clock onto the idle level
  assign sclk = sclk_q ^ (byp_q & clk);

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk (
  input logic clk,
  input logic rst,
  input logic run,
  input logic active,
  input logic byp,
  input logic lvl_act,
  input logic sclk_q,
  input logic cpol,
  input logic cpha_o,
  input logic cpha_i,
  input logic half_done,
  input logic shift_stb,
  input logic sample_stb
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !active |-> (!shift_stb && !sample_stb));

  // R6
  shift_lead_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !byp && shift_stb && cpha_o) |-> (sclk_q != cpol));

  // R6
  shift_trail_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !byp && shift_stb && !cpha_o) |-> (sclk_q == cpol));

  // R7
  same_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !byp && (cpha_i != cpha_o)) |-> (shift_stb == sample_stb));

  // R2
  toggle_on_half_chk: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !byp && (sclk_q != $past(sclk_q))) |-> $past(half_done));

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !byp && !run && !lvl_act) |=> (sclk_q == $past(sclk_q)));

endmodule

bind spi_sclk_gen spi_sclk_gen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .run        (run),
  .active     (active_q),
  .byp        (byp_q),
  .lvl_act    (level_q),
  .sclk_q     (sclk_q),
  .cpol       (mode_q.cpol),
  .cpha_o     (mode_q.cpha_out),
  .cpha_i     (mode_q.cpha_in),
  .half_done  (half_done),
  .shift_stb  (shift_stb),
  .sample_stb (sample_stb)
);

// File: tb/spi_sclk_gen_tb_top.sv
`timescale 1ns/1ps
module spi_sclk_gen_tb_top;

  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             run = 1'b0;
  logic             cs1_sel = 1'b0;
  logic [DIV_W-1:0] div_main = '0;
  logic [DIV_W-1:0] div_alt = '0;
  logic             alt_en = 1'b0;
  logic [2:0]       mode = 3'b000;
  logic             sclk, shift_stb, sample_stb;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spi_sclk_gen #(.DIV_W(DIV_W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .cs1_sel    (cs1_sel),
    .div_main   (div_main),
    .div_alt    (div_alt),
    .alt_en     (alt_en),
    .mode       (mode),
    .sclk       (sclk),
    .shift_stb  (shift_stb),
    .sample_stb (sample_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one transfer at divider nexp (>=2), then stop and check the return to idle
  task automatic run_case(input int dm, input int da, input bit ae, input bit cs,
                          input int md, input int nexp, input bit mid, input string tag);
    int lhi, llo, lidle, lact, k_total;
    bit cpol, cpo, cpi, prev;
    cpol = md[0]; cpo = md[1]; cpi = md[2];
    lhi = nexp / 2; llo = nexp - lhi;
    lidle = cpol ? lhi : llo;
    lact  = cpol ? llo : lhi;
    k_total = lidle + 3 * nexp;
    @(negedge clk);
    div_main = dm[DIV_W-1:0]; div_alt = da[DIV_W-1:0];
    alt_en = ae; cs1_sel = cs; mode = md[2:0]; run = 1'b1;
    prev = cpol;
    for (int k = 0; k < k_total; k++) begin
      bit act, lead, trail;
      int u;
      @(posedge clk); #1;
      if (k < lidle) begin
        act = 1'b0; lead = 1'b0; trail = 1'b0;
      end else begin
        u = (k - lidle) % nexp;
        act = (u < lact); lead = (u == 0); trail = (u == lact);
      end
      chk(sclk == (cpol ^ act), (k == lidle) ? "R5" : tag, sclk, cpol ^ act);
      chk(shift_stb == (cpo ? lead : trail), "R6", shift_stb, cpo ? lead : trail);
      chk(sample_stb == (cpi ? trail : lead), "R7", sample_stb, cpi ? trail : lead);
      if (mid && k == 3) begin
        // R9: new settings during the run must not reach the waveform
        div_main = 8'd2; div_alt = 8'd7; mode = ~md[2:0];
      end
      prev = sclk;
    end
    @(negedge clk);
    div_main = dm[DIV_W-1:0]; mode = md[2:0]; run = 1'b0;
    for (int j = 0; j < 2 * nexp + 4; j++) begin
      @(posedge clk); #1;
      // R10: no idle-to-active transition after run is dropped
      chk(!(prev == cpol && sclk != cpol), "R10", sclk, cpol);
      prev = sclk;
    end
    chk(sclk == cpol, "R1", sclk, cpol);
    chk(!shift_stb && !sample_stb, "R1", {shift_stb, sample_stb}, 0);
  endtask

  // divide-by-1 pass-through
  task automatic byp_case(input int md);
    bit cpol;
    cpol = md[0];
    @(negedge clk);
    div_main = 8'd1; alt_en = 1'b0; cs1_sel = 1'b0; mode = md[2:0]; run = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk(sclk == !cpol, "R4", sclk, !cpol);
      chk(shift_stb && sample_stb, "R4", {shift_stb, sample_stb}, 3);
      @(negedge clk); #1;
      chk(sclk == cpol, "R4", sclk, cpol);
    end
    @(negedge clk);
    run = 1'b0;
    @(posedge clk); #1;
    chk(sclk == cpol, "R10", sclk, cpol);
    chk(!shift_stb && !sample_stb, "R10", {shift_stb, sample_stb}, 0);
    @(negedge clk); #1;
    chk(sclk == cpol, "R10", sclk, cpol);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    mode = 3'b001;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(sclk == 1'b1, "R1", sclk, 1);
    chk(!shift_stb && !sample_stb, "R1", {shift_stb, sample_stb}, 0);
    @(negedge clk); mode = 3'b110;
    @(posedge clk); @(posedge clk); #1;
    // R11: bit 0 alone sets the idle level
    chk(sclk == 1'b0, "R11", sclk, 0);

    for (int n = 2; n <= 9; n++)
      for (int m = 0; m < 8; m++)
        run_case(n, 0, 1'b0, 1'b0, m, n, 1'b0, "R2");
    run_case(0, 0, 1'b0, 1'b0, 0, 256, 1'b0, "R3");
    run_case(0, 0, 1'b0, 1'b0, 3, 256, 1'b0, "R3");
    run_case(255, 0, 1'b0, 1'b0, 1, 255, 1'b0, "R2");
    for (int m = 0; m < 8; m++) byp_case(m);
    run_case(6, 3, 1'b1, 1'b1, 0, 3, 1'b0, "R8");
    run_case(6, 3, 1'b0, 1'b1, 1, 6, 1'b0, "R8");
    run_case(6, 3, 1'b1, 1'b0, 2, 6, 1'b0, "R8");
    run_case(6, 0, 1'b1, 1'b1, 5, 256, 1'b0, "R8");
    run_case(5, 0, 1'b0, 1'b0, 2, 5, 1'b1, "R9");
    run_case(7, 0, 1'b0, 1'b0, 5, 7, 1'b1, "R9");
    repeat (4) @(posedge clk);
    summary();
  end

endmodule